// File: doc/BRIEF.md
# Multiplexor Receive Channel Sequencer

This block sits between the receive side of a multi-line character multiplexor and a byte-oriented I/O channel. It runs a four-state sequence. A start request moves it out of idle into a command fetch. A good fetch moves it into receive, where every character taken from a line goes to memory as a two-byte record. When the channel reports that its byte count has run out, the sequencer signals channel end. The channel's answer to that decides the next state: with command chaining it fetches the next command, and otherwise it goes idle.

Each line has one character register and a pending flag. A character that arrives while the sequencer is in receive marks its line as pending. The pair writer then drains pending lines one record at a time, in a fixed priority order. Characters that arrive in any other state only update the line register and never reach memory. A halt request beats everything else: it forces idle and clears the receive and transmit interrupt requests. The channel and memory models are outside the block and talk to it through simple request and acknowledge ports.

Top module: `mux_rx_chan_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (idle) and `dev_status` is 5'b00001. `cmd_req`, `wr_valid`, `end_req`, `rx_irq` and `tx_irq` are all low.
- R2: `seq_state` encodes idle=0, init=1, receive=2 and end=3. In idle, `sio_req` moves the sequencer to init, where `cmd_req` is high. In any other state `sio_req` has no effect.
- R3: In init, `cmd_ack` with `cmd_err` low moves the sequencer to receive. `cmd_ack` with `cmd_err` high pulses `unusual_end` for one cycle and returns to idle.
- R4: In receive, each taken character produces two accepted byte writes. The character byte comes first. The line-number byte comes second, zero-extended to 8 bits. `wr_valid` and `wr_data` hold steady until `wr_ready`.
- R5: `rx_irq` is set in the cycle after the line-number byte of a record is accepted without error. It then stays set until a halt.
- R6: If `wr_zbc` is high when the line-number byte is accepted, the sequencer enters end, where `end_req` is high.
- R7: In end, `end_ack` has three outcomes. With `end_chain` high it goes to init. With `end_chain` low it goes to idle. With `end_err` high it goes to idle and pulses `unusual_end`.
- R8: `hio_req` forces idle from any state in the next cycle and clears `rx_irq` and `tx_irq`. It wins over `sio_req` in the same cycle. A `tx_irq_set` pulse sets `tx_irq`.
- R9: `dev_status` has the layout {cc[1:0], dev_busy, ctl_busy, auto}. It reads 5'b00001 in idle and 5'b10111 (cc=2, both busy bits, auto) in every other state.
- R10: A character received outside receive is never written to memory, and pending flags are dropped on leaving receive. While a line is pending, a newer character on the same line replaces the older one, so only the latest is written.
- R11: When several lines are pending, the lowest line number is written first (default `LOW_FIRST`=1).
- R12: If `wr_err` is high when either byte is accepted, the sequencer pulses `unusual_end`, returns to idle and does not raise `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sio_req | input | 1 | Start request |
| hio_req | input | 1 | Halt request |
| dev_status | output | 5 | Status word {cc, dev_busy, ctl_busy, auto} |
| seq_state | output | 2 | Sequencer state code |
| cmd_req | output | 1 | Command fetch request (init) |
| cmd_ack | input | 1 | Command fetch complete |
| cmd_err | input | 1 | Command fetch failed |
| rx_valid | input | 1 | Received character strobe |
| rx_line | input | LW | Source line of the character |
| rx_char | input | 8 | Received character |
| wr_valid | output | 1 | Byte write request |
| wr_data | output | 8 | Byte to write |
| wr_ready | input | 1 | Byte accepted this cycle |
| wr_err | input | 1 | Accepted byte had a channel error |
| wr_zbc | input | 1 | Byte count reached zero with this byte |
| end_req | output | 1 | Channel end request (end state) |
| end_ack | input | 1 | Channel end answered |
| end_chain | input | 1 | Answer requests command chaining |
| end_err | input | 1 | Answer reports a channel error |
| unusual_end | output | 1 | One-cycle unusual-end pulse |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq_set | input | 1 | Set the transmit interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that the channel answers only what the block asks for. `cmd_ack` matters only in init, `end_ack` only in end, and the error and zero-count qualifiers only alongside their acknowledge. Outside those windows the block ignores them. The assertions also assume that `rx_line` stays below the line count. The stimulus drives every input for a whole cycle, starting just after a falling edge. It raises an acknowledge only while the matching request is high, and it uses line numbers 0 to 7 only. Stalls come from holding `wr_ready` low while characters queue up on other lines.

// File: rtl/mux_rx_pkg.sv
package mux_rx_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_INIT = 2'd1,
      SQ_RECV = 2'd2,
      SQ_END  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_NONE = 2'd0,
      PH_CHAR = 2'd1,
      PH_LINE = 2'd2
   } pair_phase_e;

   typedef struct packed {
      logic [1:0] cc;
      logic       dev_busy;
      logic       ctl_busy;
      logic       auto_mode;
   } dev_status_t;

   localparam logic [1:0] BUSY_CC = 2'd2;

endpackage

// File: rtl/mux_rx_store.sv
module mux_rx_store #(
   parameter int LINES     = 8,
   parameter int BYTE_W    = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int LW       = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_en,
   input  logic              rx_valid,
   input  logic [LW-1:0]     rx_line,
   input  logic [BYTE_W-1:0] rx_char,
   input  logic              take,
   output logic              any_pend,
   output logic [LW-1:0]     pick_line,
   output logic [BYTE_W-1:0] pick_char
);

   logic [LINES-1:0][BYTE_W-1:0] rbuf;
   logic [LINES-1:0]             pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbuf <= '0;
         pend <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (rx_valid && rx_line == LW'(i)) begin
               rbuf[i] <= rx_char;
            end
            if (!capture_en) begin
               pend[i] <= 1'b0;
            end else if (rx_valid && rx_line == LW'(i)) begin
               pend[i] <= 1'b1;
            end else if (take && pick_line == LW'(i)) begin
               pend[i] <= 1'b0;
            end
         end
      end
   end

   assign any_pend = |pend;

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            pick_line = '0;
            for (int i = LINES - 1; i >= 0; i--) begin
               if (pend[i]) pick_line = LW'(i);
            end
         end
      end else begin : g_high_first
         always_comb begin
            pick_line = '0;
            for (int i = 0; i < LINES; i++) begin
               if (pend[i]) pick_line = LW'(i);
            end
         end
      end
   endgenerate

   assign pick_char = rbuf[pick_line];

   a_r10_drop_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_en |=> pend == '0);

   a_r11_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
      any_pend |-> pend[pick_line]);

endmodule

// File: rtl/mux_rx_fsm.sv
module mux_rx_fsm
   import mux_rx_pkg::*;
#(
   parameter int LW     = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sio,
   input  logic              hio,
   input  logic              cmd_ack,
   input  logic              cmd_err,
   input  logic              wr_ready,
   input  logic              wr_err,
   input  logic              wr_zbc,
   input  logic              end_ack,
   input  logic              end_chain,
   input  logic              end_err,
   input  logic              any_pend,
   input  logic [LW-1:0]     pick_line,
   input  logic [BYTE_W-1:0] pick_char,
   output seq_state_e        state,
   output logic              cmd_req,
   output logic              end_req,
   output logic              wr_valid,
   output logic [BYTE_W-1:0] wr_data,
   output logic              take,
   output logic              pair_done,
   output logic              uend
);

   pair_phase_e       phase, phase_n;
   seq_state_e        state_n;
   logic [LW-1:0]     cur_line;
   logic [BYTE_W-1:0] cur_char;
   logic              wr_fire;

   assign cmd_req   = (state == SQ_INIT);
   assign end_req   = (state == SQ_END);
   assign wr_valid  = (state == SQ_RECV) && (phase != PH_NONE);
   assign wr_data   = (phase == PH_LINE) ? BYTE_W'(cur_line) : cur_char;
   assign take      = (state == SQ_RECV) && (phase == PH_NONE) && any_pend && !hio;
   assign wr_fire   = wr_valid && wr_ready;
   assign pair_done = wr_fire && (phase == PH_LINE) && !wr_err && !hio;
   assign uend      = !hio && ((cmd_req && cmd_ack && cmd_err) ||
                               (wr_fire && wr_err) ||
                               (end_req && end_ack && end_err));

   always_comb begin
      state_n = state;
      phase_n = phase;
      if (hio) begin
         state_n = SQ_IDLE;
         phase_n = PH_NONE;
      end else begin
         unique case (state)
            SQ_IDLE: if (sio) state_n = SQ_INIT;
            SQ_INIT: if (cmd_ack) state_n = cmd_err ? SQ_IDLE : SQ_RECV;
            SQ_RECV: begin
               unique case (phase)
                  PH_NONE: if (take) phase_n = PH_CHAR;
                  PH_CHAR: if (wr_ready) begin
                     if (wr_err) begin
                        state_n = SQ_IDLE;
                        phase_n = PH_NONE;
                     end else begin
                        phase_n = PH_LINE;
                     end
                  end
                  PH_LINE: if (wr_ready) begin
                     phase_n = PH_NONE;
                     if (wr_err)      state_n = SQ_IDLE;
                     else if (wr_zbc) state_n = SQ_END;
                  end
                  default: phase_n = PH_NONE;
               endcase
            end
            SQ_END: if (end_ack) begin
               if (end_err)        state_n = SQ_IDLE;
               else if (end_chain) state_n = SQ_INIT;
               else                state_n = SQ_IDLE;
            end
            default: state_n = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         phase    <= PH_NONE;
         cur_line <= '0;
         cur_char <= '0;
      end else begin
         state <= state_n;
         phase <= phase_n;
         if (take) begin
            cur_line <= pick_line;
            cur_char <= pick_char;
         end
      end
   end

   a_r8_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      hio |=> state == SQ_IDLE);

   a_r4_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !wr_err && phase == PH_CHAR && !hio)
      |=> (wr_valid && wr_data == BYTE_W'($past(cur_line))));

   a_r3_fetch_error: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_INIT && cmd_ack && cmd_err && !hio) |=> state == SQ_IDLE);

   a_r7_chain_init: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_END && end_ack && end_chain && !end_err && !hio)
      |=> state == SQ_INIT);

   a_r12_no_done_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && wr_err) |-> !pair_done);

endmodule

// File: rtl/mux_rx_irq.sv
module mux_rx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic hio,
   input  logic rx_set,
   input  logic tx_set,
   output logic rx_irq,
   output logic tx_irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_irq <= 1'b0;
         tx_irq <= 1'b0;
      end else if (hio) begin
         rx_irq <= 1'b0;
         tx_irq <= 1'b0;
      end else begin
         if (rx_set) rx_irq <= 1'b1;
         if (tx_set) tx_irq <= 1'b1;
      end
   end

   a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      hio |=> (!rx_irq && !tx_irq));

   a_r5_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !hio) |=> rx_irq);

endmodule

// File: rtl/mux_rx_chan_seq.sv
module mux_rx_chan_seq
   import mux_rx_pkg::*;
#(
   parameter int LINES     = 8,
   parameter int BYTE_W    = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int LW       = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sio_req,
   input  logic              hio_req,
   output logic [4:0]        dev_status,
   output logic [1:0]        seq_state,
   output logic              cmd_req,
   input  logic              cmd_ack,
   input  logic              cmd_err,
   input  logic              rx_valid,
   input  logic [LW-1:0]     rx_line,
   input  logic [BYTE_W-1:0] rx_char,
   output logic              wr_valid,
   output logic [BYTE_W-1:0] wr_data,
   input  logic              wr_ready,
   input  logic              wr_err,
   input  logic              wr_zbc,
   output logic              end_req,
   input  logic              end_ack,
   input  logic              end_chain,
   input  logic              end_err,
   output logic              unusual_end,
   output logic              rx_irq,
   input  logic              tx_irq_set,
   output logic              tx_irq
);

   generate
      if (LINES < 2 || LINES > 256) begin : g_bad_lines
         $error("mux_rx_chan_seq: LINES must lie in 2..256");
      end
      if (BYTE_W < LW) begin : g_bad_width
         $error("mux_rx_chan_seq: line number does not fit one byte");
      end
   endgenerate

   seq_state_e        state;
   logic              any_pend;
   logic              take;
   logic              pair_done;
   logic [LW-1:0]     pick_line;
   logic [BYTE_W-1:0] pick_char;
   dev_status_t       stat;

   mux_rx_store #(
      .LINES     (LINES),
      .BYTE_W    (BYTE_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (state == SQ_RECV),
      .rx_valid   (rx_valid),
      .rx_line    (rx_line),
      .rx_char    (rx_char),
      .take       (take),
      .any_pend   (any_pend),
      .pick_line  (pick_line),
      .pick_char  (pick_char)
   );

   mux_rx_fsm #(
      .LW     (LW),
      .BYTE_W (BYTE_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sio       (sio_req),
      .hio       (hio_req),
      .cmd_ack   (cmd_ack),
      .cmd_err   (cmd_err),
      .wr_ready  (wr_ready),
      .wr_err    (wr_err),
      .wr_zbc    (wr_zbc),
      .end_ack   (end_ack),
      .end_chain (end_chain),
      .end_err   (end_err),
      .any_pend  (any_pend),
      .pick_line (pick_line),
      .pick_char (pick_char),
      .state     (state),
      .cmd_req   (cmd_req),
      .end_req   (end_req),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .take      (take),
      .pair_done (pair_done),
      .uend      (unusual_end)
   );

   mux_rx_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .hio    (hio_req),
      .rx_set (pair_done),
      .tx_set (tx_irq_set),
      .rx_irq (rx_irq),
      .tx_irq (tx_irq)
   );

   always_comb begin
      stat.auto_mode = 1'b1;
      stat.ctl_busy  = (state != SQ_IDLE);
      stat.dev_busy  = (state != SQ_IDLE);
      stat.cc        = (state != SQ_IDLE) ? BUSY_CC : 2'd0;
   end

   assign dev_status = stat;
   assign seq_state  = state;

   a_r5_irq_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> $past(wr_valid && wr_ready && !wr_err));

   a_r9_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req || end_req || wr_valid) |-> (dev_status[1] && dev_status[2]));

endmodule

// File: tb/test_mux_rx_chan_seq.sv
module test_mux_rx_chan_seq;

   localparam int LINES = 8;
   localparam int LW    = $clog2(LINES);
   localparam int NVEC  = 6;
   localparam logic [15:0] VEC [NVEC] = '{
      16'h0041, 16'h0742, 16'h0343, 16'h015A, 16'h0600, 16'h02FF
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sio_req = 0, hio_req = 0, cmd_ack = 0, cmd_err = 0;
   logic rx_valid = 0;
   logic [LW-1:0] rx_line = '0;
   logic [7:0] rx_char = '0;
   logic wr_ready = 1, wr_err = 0, wr_zbc = 0;
   logic end_ack = 0, end_chain = 0, end_err = 0, tx_irq_set = 0;
   logic [4:0] dev_status;
   logic [1:0] seq_state;
   logic cmd_req, wr_valid, end_req, unusual_end, rx_irq, tx_irq;
   logic [7:0] wr_data;

   int checks = 0, failures = 0, cyc = 0, wcnt = 0, ucnt = 0;
   logic [7:0] wlog [256];
   bit done = 0;

   always #2.5 clk = ~clk;

   mux_rx_chan_seq #(.LINES(LINES)) i_mux_rx_chan_seq (
      .clk(clk), .rst_n(rst_n), .sio_req(sio_req), .hio_req(hio_req),
      .dev_status(dev_status), .seq_state(seq_state), .cmd_req(cmd_req),
      .cmd_ack(cmd_ack), .cmd_err(cmd_err), .rx_valid(rx_valid),
      .rx_line(rx_line), .rx_char(rx_char), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ready(wr_ready), .wr_err(wr_err),
      .wr_zbc(wr_zbc), .end_req(end_req), .end_ack(end_ack),
      .end_chain(end_chain), .end_err(end_err), .unusual_end(unusual_end),
      .rx_irq(rx_irq), .tx_irq_set(tx_irq_set), .tx_irq(tx_irq)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (wr_valid && wr_ready && !wr_err) begin
            wlog[wcnt[7:0]] <= wr_data;
            wcnt <= wcnt + 1;
         end
         if (unusual_end) ucnt <= ucnt + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [LW-1:0] ln, input logic [7:0] ch);
      rx_valid = 1; rx_line = ln; rx_char = ch;
      tick(1);
      rx_valid = 0;
   endtask

   task automatic do_sio();
      sio_req = 1; tick(1); sio_req = 0;
   endtask

   task automatic do_fetch();
      cmd_ack = 1; tick(1); cmd_ack = 0;
   endtask

   task automatic do_end(input logic chain, input logic err);
      end_ack = 1; end_chain = chain; end_err = err;
      tick(1);
      end_ack = 0; end_chain = 0; end_err = 0;
   endtask

   initial begin
      int base, u;
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 state", seq_state, 0);
      chk("R1 status", dev_status, 5'b00001);
      chk("R1 outputs", {cmd_req, wr_valid, end_req, rx_irq, tx_irq}, 0);

      // R10 character while idle is not written
      send(3'd1, 8'h11);
      tick(4);
      chk("R10 idle char", wcnt, 0);

      // R2 start into init, R9 busy status
      do_sio();
      chk("R2 init", {seq_state, cmd_req}, {2'd1, 1'b1});
      chk("R9 busy status", dev_status, 5'b10111);
      do_sio();
      chk("R2 sio ignored", seq_state, 1);
      do_fetch();
      chk("R3 fetch ok", seq_state, 2);
      tick(3);
      chk("R10 old pending dropped", wcnt, 0);

      // R4 main function, table walk
      for (int k = 0; k < NVEC; k++) begin
         send(VEC[k][LW+7:8], VEC[k][7:0]);
         tick(5);
         chk("R4 count", wcnt, 2 * (k + 1));
         chk("R4 char byte", wlog[wcnt - 2], VEC[k][7:0]);
         chk("R4 line byte", wlog[wcnt - 1], {5'd0, VEC[k][LW+7:8]});
      end
      chk("R5 rx_irq", rx_irq, 1);

      // R4 hold under stall, R11 priority, R10 overwrite
      base = wcnt;
      wr_ready = 0;
      send(3'd4, 8'h54);
      tick(2);
      chk("R4 hold valid", {wr_valid, wr_data}, {1'b1, 8'h54});
      send(3'd6, 8'h61);
      send(3'd3, 8'h62);
      send(3'd6, 8'h63);
      tick(1);
      chk("R4 still held", {wr_valid, wr_data}, {1'b1, 8'h54});
      wr_ready = 1;
      tick(10);
      chk("R11 count", wcnt, base + 6);
      chk("R11 first line", {wlog[base], wlog[base+1]}, 16'h5404);
      chk("R11 low line first", {wlog[base+2], wlog[base+3]}, 16'h6203);
      chk("R10 latest kept", {wlog[base+4], wlog[base+5]}, 16'h6306);

      // R6 zero count -> end, R7 chain
      wr_zbc = 1;
      send(3'd2, 8'h70);
      tick(5);
      wr_zbc = 0;
      chk("R6 end state", {seq_state, end_req}, {2'd3, 1'b1});
      do_end(1, 0);
      chk("R7 chain to init", seq_state, 1);
      do_fetch();
      wr_zbc = 1;
      send(3'd0, 8'h71);
      tick(5);
      wr_zbc = 0;
      chk("R6 end again", seq_state, 3);
      do_end(0, 0);
      chk("R7 no chain idle", seq_state, 0);
      chk("R9 idle status", dev_status, 5'b00001);
      chk("R5 irq kept", rx_irq, 1);

      // R10 idle char then start: not written
      base = wcnt;
      send(3'd5, 8'h7A);
      tick(2);
      do_sio();
      do_fetch();
      tick(6);
      chk("R10 not written later", wcnt, base);

      // R8 halt
      tx_irq_set = 1; tick(1); tx_irq_set = 0;
      chk("R8 tx_irq set", tx_irq, 1);
      hio_req = 1; tick(1); hio_req = 0;
      chk("R8 halt idle", seq_state, 0);
      chk("R8 irqs cleared", {rx_irq, tx_irq}, 0);
      hio_req = 1; sio_req = 1; tick(1); hio_req = 0; sio_req = 0;
      chk("R8 halt beats start", seq_state, 0);

      // R3 fetch error
      u = ucnt;
      do_sio();
      cmd_ack = 1; cmd_err = 1; tick(1); cmd_ack = 0; cmd_err = 0;
      chk("R3 fetch err idle", seq_state, 0);
      chk("R3 unusual end", ucnt, u + 1);

      // R12 write error
      do_sio();
      do_fetch();
      base = wcnt;
      wr_err = 1;
      send(3'd1, 8'h33);
      tick(4);
      wr_err = 0;
      chk("R12 idle", seq_state, 0);
      chk("R12 unusual end", ucnt, u + 2);
      chk("R12 no irq", rx_irq, 0);
      chk("R12 nothing logged", wcnt, base);

      // R7 end error
      do_sio();
      do_fetch();
      wr_zbc = 1;
      send(3'd7, 8'h44);
      tick(5);
      wr_zbc = 0;
      chk("R7 reached end", seq_state, 3);
      do_end(1, 1);
      chk("R7 end err idle", seq_state, 0);
      chk("R7 unusual end", ucnt, u + 3);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule